// File: doc/BRIEF.md
# Multi-Bank Flash Sector Map

This block sits between the host-facing decode of a 4M-word (16-bit word) flash array and the read and write paths. It maps a 22-bit word address to one of four banks, a sector number that is global across the device and a flag that marks the sector as small (4K words) rather than large (32K words). The banks have unequal sizes. The first and last banks each hold 8 Mbit, made of eight small sectors plus fifteen large ones. The two middle banks each hold 24 Mbit, made of forty-eight large sectors.

The block remembers which bank, if any, is running an embedded program or erase. Every access gets two qualifiers. `read_ok` says whether the array can serve a read at once or whether status must be returned because the addressed bank is busy. `wr_blocked` says whether a program or erase to that sector must be refused. A sector is blocked if its own lock bit is set. It is also blocked if the write-protect pin is low and the sector is one of the two lowest or two highest small sectors. The block holds no array data and does not sequence commands.

Top module: `flash_sector_map`

## Requirements
- R1: `bank` decodes as 0 for addresses below 0x080000, as 1 from 0x080000 up to 0x1FFFFF, as 2 from 0x200000 up to 0x37FFFF, and as 3 from 0x380000 upward.
- R2: `sector` numbers all 142 sectors upward with the address. Addresses below 0x8000 give addr/4096 (0..7). Addresses from 0x8000 up to 0x3F7FFF give 8 + (addr−0x8000)/32768 (8..133). Addresses from 0x3F8000 upward give 134 + (addr−0x3F8000)/4096 (134..141).
- R3: `small_sec` is 1 exactly for sectors 0..7 and 134..141.
- R4: After reset, `busy` is 0 and every lock bit is clear.
- R5: An `op_start` pulse while `busy` is 0 makes `busy` 1 and sets `busy_bank` to the bank of `addr` from the next clock edge onward.
- R6: An `op_start` pulse while `busy` is 1 is ignored, and `busy_bank` keeps its value.
- R7: An `op_done` pulse while busy clears `busy` at the next edge. While busy without `op_done`, `busy` and `busy_bank` hold their values.
- R8: `read_ok` is 0 only when `busy` is 1 and `bank` equals `busy_bank`. Reads of every other bank give 1.
- R9: A `lock_we` pulse writes `lock_val` into the lock bit of sector `lock_sel` at the next edge. A `lock_sel` of 142 or above changes no lock bit.
- R10: `wr_blocked` is 1 whenever the addressed sector's lock bit is set.
- R11: With `wp_n` low, `wr_blocked` is 1 for sectors 0, 1, 140 and 141, whatever their lock bits. No other sector is affected by `wp_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 22 | Word address of the current access |
| wp_n | input | 1 | Write-protect pin, active low |
| op_start | input | 1 | An embedded program/erase begins at `addr` |
| op_done | input | 1 | The running embedded operation has finished |
| lock_we | input | 1 | Lock bit write strobe |
| lock_sel | input | 8 | Sector whose lock bit is written |
| lock_val | input | 1 | Value written to the lock bit |
| bank | output | 2 | Decoded bank (0..3) |
| sector | output | 8 | Global sector number (0..141) |
| small_sec | output | 1 | Sector is 4K words |
| busy | output | 1 | An embedded operation is running |
| busy_bank | output | 2 | Bank of the running operation |
| read_ok | output | 1 | Read may be served from the array |
| wr_blocked | output | 1 | Program/erase to this sector is refused |

## Verification
The assertions cover the busy-tracker hand-offs on every cycle. They check that a start when idle captures the bank, that a start while busy leaves the bank unchanged, and that done clears the state. They also check that a lock write lands in the chosen bit, that read_ok goes low only for the busy bank, and that small sectors occur only in the outer banks. The full address-to-sector layout, with its uneven bank boundaries, is shown only by the bench's sweep of every 4K-word step. The same holds for the exact set of four sectors covered by write-protect.

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
  parameter int ADDR_W   = 22,
  parameter int SMALL_SH = 12,
  parameter int LARGE_SH = 15,
  parameter int SMALL_N  = 8,
  parameter int WP_N_SEC = 2,
  parameter logic [21:0] BANK_B_BASE = 22'h080000,
  parameter logic [21:0] BANK_C_BASE = 22'h200000,
  parameter logic [21:0] BANK_D_BASE = 22'h380000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  input  logic              op_start,
  input  logic              op_done,
  input  logic              lock_we,
  input  logic [7:0]        lock_sel,
  input  logic              lock_val,
  output logic [1:0]        bank,
  output logic [7:0]        sector,
  output logic              small_sec,
  output logic              busy,
  output logic [1:0]        busy_bank,
  output logic              read_ok,
  output logic              wr_blocked
);
  localparam int HI_W      = ADDR_W - LARGE_SH;
  localparam int SUB_W     = LARGE_SH - SMALL_SH;
  localparam int LARGE_TOP = (1 << HI_W) - 1;
  localparam int NSEC      = 2 * SMALL_N + LARGE_TOP - 1;
  localparam int HI_BASE   = SMALL_N + LARGE_TOP - 1;

  logic [HI_W-1:0]  hi;
  logic [SUB_W-1:0] sub;
  logic             small_lo, small_hi;
  logic [NSEC-1:0]  lock_q;

  assign hi       = addr[ADDR_W-1:LARGE_SH];
  assign sub      = addr[LARGE_SH-1:SMALL_SH];
  assign small_lo = (hi == '0);
  assign small_hi = (hi == HI_W'(LARGE_TOP));
  assign small_sec = small_lo | small_hi;

  always_comb begin
    if (small_lo)      sector = 8'(sub);
    else if (small_hi) sector = 8'(HI_BASE) + 8'(sub);
    else               sector = 8'(hi) + 8'(SMALL_N - 1);
  end

  always_comb begin
    if (addr < BANK_B_BASE)      bank = 2'd0;
    else if (addr < BANK_C_BASE) bank = 2'd1;
    else if (addr < BANK_D_BASE) bank = 2'd2;
    else                         bank = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      busy_bank <= 2'd0;
    end else if (busy) begin
      if (op_done) busy <= 1'b0;
    end else if (op_start) begin
      busy      <= 1'b1;
      busy_bank <= bank;
    end
  end

  generate
    for (genvar s = 0; s < NSEC; s++) begin : g_lock
      always_ff @(posedge clk) begin
        if (!rst_n)
          lock_q[s] <= 1'b0;
        else if (lock_we && lock_sel == 8'(s))
          lock_q[s] <= lock_val;
      end
    end
  endgenerate

  assign read_ok    = !(busy && bank == busy_bank);
  assign wr_blocked = lock_q[sector] |
                      (!wp_n && (sector < 8'(WP_N_SEC) || sector >= 8'(NSEC - WP_N_SEC)));

  // R2
  sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sector < 8'(NSEC));
  // R3
  small_outer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    small_sec |-> (bank == 2'd0 || bank == 2'd3));
  // R5
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !busy) |=> (busy && busy_bank == $past(bank)));
  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && busy) |=> $stable(busy_bank));
  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> !busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> (busy && $stable(busy_bank)));
  // R8
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !read_ok |-> (busy && bank == busy_bank));
  // R9
  lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_we && lock_sel < 8'(NSEC)) |=> (lock_q[$past(lock_sel)] == $past(lock_val)));
  // R10
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[sector] |-> wr_blocked);
endmodule

// File: tb/test_flash_sector_map.sv
module test_flash_sector_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] addr = '0;
  logic        wp_n = 1'b1;
  logic        op_start = 1'b0, op_done = 1'b0;
  logic        lock_we = 1'b0, lock_val = 1'b0;
  logic [7:0]  lock_sel = '0;
  logic [1:0]  bank, busy_bank;
  logic [7:0]  sector;
  logic        small_sec, busy, read_ok, wr_blocked;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  flash_sector_map i_flash_sector_map (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wp_n(wp_n),
    .op_start(op_start), .op_done(op_done),
    .lock_we(lock_we), .lock_sel(lock_sel), .lock_val(lock_val),
    .bank(bank), .sector(sector), .small_sec(small_sec),
    .busy(busy), .busy_bank(busy_bank), .read_ok(read_ok), .wr_blocked(wr_blocked)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (addr %h)", req, act, exp, addr);
    end
  endtask

  function automatic int exp_bank(input int a);
    if (a >= 'h380000) return 3;
    if (a >= 'h200000) return 2;
    if (a >= 'h080000) return 1;
    return 0;
  endfunction

  function automatic int exp_sector(input int a);
    if (a < 'h8000)    return a / 4096;
    if (a < 'h3F8000) return 8 + (a - 'h8000) / 32768;
    return 134 + (a - 'h3F8000) / 4096;
  endfunction

  function automatic logic [21:0] sec_addr(input int s);
    if (s < 8)   return 22'(s * 4096);
    if (s < 134) return 22'('h8000 + (s - 8) * 32768);
    return 22'('h3F8000 + (s - 134) * 4096);
  endfunction

  task automatic step();
    @(posedge clk); #5;
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R4 reset state
    chk("R4 busy", busy, 0);
    for (int s = 0; s < 142; s++) begin
      addr = sec_addr(s); #1;
      chk("R4 lock clear", wr_blocked, 0);
    end

    // R1 R2 R3 sweep at 4K steps, offsets 0 and 0xFFF
    for (int k = 0; k < 1024; k++) begin
      for (int o = 0; o < 2; o++) begin
        int a;
        a = k * 4096 + o * 'hFFF;
        addr = 22'(a); #1;
        chk("R1 bank", bank, exp_bank(a));
        chk("R2 sector", sector, exp_sector(a));
        chk("R3 small", small_sec, (exp_sector(a) < 8 || exp_sector(a) >= 134) ? 1 : 0);
      end
    end

    // R5 R7 R8 busy tracking per bank
    for (int b = 0; b < 4; b++) begin
      logic [21:0] base;
      base = (b == 0) ? 22'h000100 : (b == 1) ? 22'h0A0000 : (b == 2) ? 22'h250000 : 22'h3FF000;
      addr = base; op_start = 1'b1; step(); op_start = 1'b0;
      chk("R5 busy set", busy, 1);
      chk("R5 busy bank", busy_bank, b);
      for (int t = 0; t < 4; t++) begin
        addr = (t == 0) ? 22'h001000 : (t == 1) ? 22'h100000 : (t == 2) ? 22'h300000 : 22'h3C0000; #1;
        chk("R8 read_ok", read_ok, (t == b) ? 0 : 1);
      end
      // R6 start while busy ignored
      addr = (b == 3) ? 22'h000000 : 22'h3FFFFF; op_start = 1'b1; step(); op_start = 1'b0;
      chk("R6 bank kept", busy_bank, b);
      chk("R7 busy hold", busy, 1);
      op_done = 1'b1; step(); op_done = 1'b0;
      chk("R7 busy clear", busy, 0);
      #1; chk("R8 idle read_ok", read_ok, 1);
    end

    // R9 R10 lock write and clear
    lock_we = 1'b1; lock_val = 1'b1;
    lock_sel = 8'd20;  step();
    lock_sel = 8'd141; step();
    lock_sel = 8'd200; step();
    lock_we = 1'b0;
    for (int s = 0; s < 142; s++) begin
      addr = sec_addr(s); #1;
      chk("R10 lock block", wr_blocked, (s == 20 || s == 141) ? 1 : 0);
    end
    lock_we = 1'b1; lock_val = 1'b0; lock_sel = 8'd20; step(); lock_we = 1'b0;
    addr = sec_addr(20); #1;
    chk("R9 lock cleared", wr_blocked, 0);
    addr = sec_addr(141); #1;
    chk("R9 other kept", wr_blocked, 1);
    lock_we = 1'b1; lock_sel = 8'd141; step(); lock_we = 1'b0;

    // R11 write-protect pin
    wp_n = 1'b0;
    for (int s = 0; s < 142; s++) begin
      addr = sec_addr(s) + 22'h0FF; #1;
      chk("R11 wp", wr_blocked, (s < 2 || s > 139) ? 1 : 0);
    end
    wp_n = 1'b1; #1;
    addr = sec_addr(0); #1;
    chk("R11 wp released", wr_blocked, 0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule